// File: doc/BRIEF.md
# Isochronous Packet Receive Checker

This block sits behind a serial-bus link layer on the isochronous receive path. Each incoming packet arrives as a header beat (tag, speed, sync bit, payload length in quadlets), a run of payload quadlets and an end beat that carries the CRC verdict. A packet is accepted only if its tag equals the value held in the control register. Its quadlets are written into a receive FIFO, and the packet's sync bit is stored beside each quadlet.

Writes are provisional until the end beat. A packet with a good CRC and a quadlet count equal to its length field is committed and gets the completion code. Any other packet gets the data-error code and the write pointer rolls back. A packet that runs into a full FIFO is discarded in the same way and raises a one-cycle overflow pulse.

Two registers are visible. The control register holds the last speed, the tag selector, the last result code and the last sync bit. The status register decodes FIFO occupancy into flags. Only committed quadlets are visible on the FIFO read side.

Top module: `iso_rx_checker`

## Requirements
- R1: After reset the control register (reg_addr=0) reads 0x00000000 and the status register (reg_addr=1) reads 0x00000003.
- R2: Only control bits 15:14 (tag selector) are writable. Writing 0xFFFFFFFF to an idle block reads back 0x0000C000.
- R3: A packet with a matching tag that ends with CRC good and quadlet count equal to its length sets the control register as follows: bits 7:4 to 0001, bits 17:16 to its speed code (00 = 100 Mbps, 01 = 200 Mbps, 10 = 400 Mbps, 11 reserved) and bit 0 to its sync bit.
- R4: A matching packet with a bad CRC or a quadlet count different from its length field sets bits 7:4 to 1101 and updates speed and sync. None of its quadlets stay in the FIFO.
- R5: A matching packet with length zero and no payload quadlets always ends with code 0001, even when its CRC indication is bad.
- R6: A packet whose tag differs from the selector writes no quadlet and leaves the control register unchanged.
- R7: The FIFO read side returns committed quadlets in arrival order. fifo_rsy equals the sync bit of the packet each quadlet came from. fifo_rd advances only while fifo_valid is high.
- R8: Status bit 0 is set when no committed quadlet is stored. Status bit 1 is set when at least 5 quadlets are free.
- R9: Status bits 4, 5 and 6 are set when free space is at most 512, 256 and 100 quadlets respectively. Bit 2 means exactly one quadlet is free. Bit 3 means none is free.
- R10: A payload quadlet that arrives while the FIFO is full drops the whole packet. The packet's earlier quadlets are rolled back, pkt_overflow pulses for one cycle, and the control register stays unchanged.
- R11: Quadlets of a packet still in progress are not readable: fifo_valid stays low until the packet commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header beat strobe |
| hdr_tag | input | 2 | Tag field of the header |
| hdr_spd | input | 2 | Speed code of the packet |
| hdr_sy | input | 1 | Sync bit of the header |
| hdr_len | input | LEN_W | Payload length in quadlets |
| data_valid | input | 1 | Payload quadlet strobe |
| data_word | input | 32 | Payload quadlet |
| pkt_end | input | 1 | End-of-packet beat |
| pkt_crc_ok | input | 1 | CRC verdict, valid with pkt_end |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fifo_rd | input | 1 | Pop one committed quadlet |
| fifo_valid | output | 1 | A committed quadlet is available |
| fifo_rdata | output | 32 | Quadlet at the FIFO head |
| fifo_rsy | output | 1 | Sync bit stored with the head quadlet |
| pkt_overflow | output | 1 | One-cycle pulse on a packet dropped for lack of space |

## Verification
The assertions check on every cycle that:
- no quadlet is written into a full FIFO;
- every rollback leaves exactly the committed data in the FIFO;
- the result code holds only reset, completion or data-error values;
- the tag selector moves only on a control write;
- the full flag never appears together with the free-space flags.

Only the bench scenarios can show the rest:
- the ordering of quadlets and sync bits across packets;
- the exact threshold crossings at 512, 256, 100, 1 and 0 free quadlets;
- that dropped and mismatched packets leave no trace;
- that a zero-length packet escapes the data-error code.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam logic [3:0] CODE_DONE     = 4'b0001;
  localparam logic [3:0] CODE_DATA_ERR = 4'b1101;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SKIP = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic        sy;
    logic [31:0] data;
  } rx_word_t;
endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  iso_rx_pkg::rx_word_t       wr_word,
  input  logic                       commit,
  input  logic                       rollback,
  input  logic                       rd_en,
  output iso_rx_pkg::rx_word_t       rd_word,
  output logic [$clog2(DEPTH):0]     used,
  output logic [$clog2(DEPTH):0]     committed
);
  localparam int AW = $clog2(DEPTH);

  iso_rx_pkg::rx_word_t mem [DEPTH];
  logic [AW:0] wr_ptr, wr_nxt, cmt_ptr, cmt_nxt, rd_ptr, rd_nxt;

  always_comb begin
    wr_nxt = wr_ptr;
    if (rollback)   wr_nxt = cmt_ptr;
    else if (wr_en) wr_nxt = wr_ptr + 1'b1;
    cmt_nxt = commit ? wr_ptr : cmt_ptr;
    rd_nxt  = (rd_en && (cmt_ptr != rd_ptr)) ? rd_ptr + 1'b1 : rd_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      wr_ptr  <= wr_nxt;
      cmt_ptr <= cmt_nxt;
      rd_ptr  <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_word;
  end

  assign rd_word   = mem[rd_ptr[AW-1:0]];
  assign used      = wr_ptr - rd_ptr;
  assign committed = cmt_ptr - rd_ptr;
endmodule

// File: rtl/iso_rx_occupancy.sv
module iso_rx_occupancy #(
  parameter int DEPTH = 1024,
  parameter int LVL_A = 512,
  parameter int LVL_B = 256,
  parameter int LVL_C = 100
) (
  input  logic [$clog2(DEPTH):0] used,
  input  logic [$clog2(DEPTH):0] committed,
  output logic [6:0]             flags
);
  localparam int AW = $clog2(DEPTH);
  localparam int LVLS [3] = '{LVL_A, LVL_B, LVL_C};

  logic [AW:0] free;
  assign free = (AW+1)'(DEPTH) - used;

  assign flags[0] = (committed == '0);
  assign flags[1] = (free >= (AW+1)'(5));
  assign flags[2] = (free == (AW+1)'(1));
  assign flags[3] = (free == '0);

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    assign flags[4+g] = (free <= (AW+1)'(LVLS[g]));
  end
endmodule

// File: rtl/iso_rx_pkt_ctl.sv
module iso_rx_pkt_ctl #(
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [1:0]             hdr_tag,
  input  logic [1:0]             hdr_spd,
  input  logic                   hdr_sy,
  input  logic [LEN_W-1:0]       hdr_len,
  input  logic                   data_valid,
  input  logic [31:0]            data_word,
  input  logic                   pkt_end,
  input  logic                   pkt_crc_ok,
  input  logic [1:0]             tag_sel,
  input  logic                   full,
  output logic                   wr_en,
  output iso_rx_pkg::rx_word_t   wr_word,
  output logic                   commit,
  output logic                   rollback,
  output logic                   overflow,
  output logic                   done,
  output logic [3:0]             done_code,
  output logic [1:0]             done_spd,
  output logic                   done_sy
);
  import iso_rx_pkg::*;

  rx_state_e        st_q, st_n;
  logic [LEN_W-1:0] len_q, len_n, cnt_q, cnt_n;
  logic [1:0]       spd_q, spd_n;
  logic             sy_q, sy_n;

  always_comb begin
    st_n      = st_q;
    len_n     = len_q;
    cnt_n     = cnt_q;
    spd_n     = spd_q;
    sy_n      = sy_q;
    wr_en     = 1'b0;
    commit    = 1'b0;
    rollback  = 1'b0;
    overflow  = 1'b0;
    done      = 1'b0;
    done_code = CODE_DONE;
    unique case (st_q)
      ST_IDLE: if (hdr_valid) begin
        if (hdr_tag == tag_sel) begin
          st_n  = ST_RECV;
          len_n = hdr_len;
          cnt_n = '0;
          spd_n = hdr_spd;
          sy_n  = hdr_sy;
        end else begin
          st_n = ST_SKIP;
        end
      end
      ST_RECV: if (pkt_end) begin
        st_n = ST_IDLE;
        done = 1'b1;
        if ((len_q == '0 && cnt_q == '0) || (pkt_crc_ok && cnt_q == len_q)) begin
          commit = 1'b1;
        end else begin
          rollback  = 1'b1;
          done_code = CODE_DATA_ERR;
        end
      end else if (data_valid) begin
        if (full) begin
          overflow = 1'b1;
          rollback = 1'b1;
          st_n     = ST_SKIP;
        end else begin
          wr_en = 1'b1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_SKIP: if (pkt_end) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      len_q <= '0;
      cnt_q <= '0;
      spd_q <= '0;
      sy_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      len_q <= len_n;
      cnt_q <= cnt_n;
      spd_q <= spd_n;
      sy_q  <= sy_n;
    end
  end

  assign wr_word  = '{sy: sy_q, data: data_word};
  assign done_spd = spd_q;
  assign done_sy  = sy_q;
endmodule

// File: rtl/iso_rx_checker.sv
module iso_rx_checker #(
  parameter int DEPTH = 1024,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [1:0]       hdr_tag,
  input  logic [1:0]       hdr_spd,
  input  logic             hdr_sy,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             data_valid,
  input  logic [31:0]      data_word,
  input  logic             pkt_end,
  input  logic             pkt_crc_ok,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fifo_rd,
  output logic             fifo_valid,
  output logic [31:0]      fifo_rdata,
  output logic             fifo_rsy,
  output logic             pkt_overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic                 wr_en, commit, rollback, done, full, done_sy;
  logic [3:0]           done_code;
  logic [1:0]           done_spd;
  iso_rx_pkg::rx_word_t wr_word, rd_word;
  logic [AW:0]          used, committed;
  logic [6:0]           stat_word;
  logic [31:0]          ctl_word;

  logic [1:0] tag_q, tag_n, spd_q, spd_n;
  logic [3:0] err_q, err_n;
  logic       sy_q, sy_n;

  assign full = (used == (AW+1)'(DEPTH));

  iso_rx_pkt_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_ni),
    .hdr_valid(hdr_valid), .hdr_tag(hdr_tag), .hdr_spd(hdr_spd), .hdr_sy(hdr_sy),
    .hdr_len(hdr_len), .data_valid(data_valid), .data_word(data_word),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .tag_sel(tag_q), .full(full),
    .wr_en(wr_en), .wr_word(wr_word), .commit(commit), .rollback(rollback),
    .overflow(pkt_overflow), .done(done), .done_code(done_code),
    .done_spd(done_spd), .done_sy(done_sy)
  );

  iso_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_word(wr_word),
    .commit(commit), .rollback(rollback), .rd_en(fifo_rd),
    .rd_word(rd_word), .used(used), .committed(committed)
  );

  iso_rx_occupancy #(.DEPTH(DEPTH)) u_occ (
    .used(used), .committed(committed), .flags(stat_word)
  );

  always_comb begin
    tag_n = tag_q;
    spd_n = spd_q;
    err_n = err_q;
    sy_n  = sy_q;
    if (reg_wr && !reg_addr) tag_n = reg_wdata[15:14];
    if (done) begin
      spd_n = done_spd;
      err_n = done_code;
      sy_n  = done_sy;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      spd_q <= '0;
      err_q <= '0;
      sy_q  <= 1'b0;
    end else begin
      tag_q <= tag_n;
      spd_q <= spd_n;
      err_q <= err_n;
      sy_q  <= sy_n;
    end
  end

  assign ctl_word   = {14'b0, spd_q, tag_q, 6'b0, err_q, 3'b0, sy_q};
  assign reg_rdata  = reg_addr ? {25'b0, stat_word} : ctl_word;
  assign fifo_valid = (committed != '0);
  assign fifo_rdata = rd_word.data;
  assign fifo_rsy   = rd_word.sy;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[13:0]};
endmodule

// File: rtl/iso_rx_checker_sva.sv
module iso_rx_checker_sva #(
  parameter int DEPTH = 1024
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   full,
  input logic                   rollback,
  input logic                   overflow,
  input logic                   done,
  input logic [3:0]             done_code,
  input logic [$clog2(DEPTH):0] used,
  input logic [$clog2(DEPTH):0] committed,
  input logic                   reg_wr,
  input logic                   reg_addr,
  input logic [31:0]            ctl_word,
  input logic [6:0]             stat_word
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R10
  AST_OVERFLOW_ROLLS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (used == committed)); // R10
  AST_ERROR_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == 4'b1101) |=> (used == committed)); // R4
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[7:4] == 4'b0000) || (ctl_word[7:4] == 4'b0001) || (ctl_word[7:4] == 4'b1101)); // R3
  AST_TAG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr) |=> $stable(ctl_word[15:14])); // R2
  AST_FULL_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[3] |-> (!stat_word[1] && !stat_word[2])); // R9
endmodule

bind iso_rx_checker iso_rx_checker_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .full(full), .rollback(rollback),
  .overflow(pkt_overflow), .done(done), .done_code(done_code), .used(used),
  .committed(committed), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctl_word(ctl_word), .stat_word(stat_word)
);

// File: tb/iso_rx_checker_test.sv
module iso_rx_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 0, hdr_sy = 0, data_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
  logic [1:0] hdr_tag = 0, hdr_spd = 0;
  logic [LEN_W-1:0] hdr_len = 0;
  logic [31:0] data_word = 0, reg_wdata = 0, reg_rdata, fifo_rdata;
  logic reg_wr = 0, reg_addr = 0, fifo_rd, fifo_valid, fifo_rsy, pkt_overflow;

  iso_rx_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, ovf_count = 0, serial = 0, m_used = 0;
  logic [32:0] exp_q[$];
  bit drain_on = 0;
  logic [1:0] cur_tag = 0, m_spd = 0;
  logic [3:0] m_err = 0;
  logic m_sy = 0;

  always @(posedge clk) if (pkt_overflow) ovf_count++;

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_stat(int u);
    int f = DEPTH - u;
    return {f <= 100, f <= 256, f <= 512, f == 0, f == 1, f >= 5, u == 0};
  endfunction

  function automatic logic [31:0] exp_ctl();
    return {14'b0, m_spd, cur_tag, 6'b0, m_err, 3'b0, m_sy};
  endfunction

  task automatic rd_reg(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    rd_reg(0, v); chk(req, {1'b0, v}, {1'b0, exp_ctl()});
    rd_reg(1, v); chk(req, {1'b0, v}, {26'b0, exp_stat(m_used)});
  endtask

  // Monitor: pops expected quadlets and compares them with the FIFO head
  initial begin
    fifo_rd = 0;
    forever begin
      @(negedge clk);
      fifo_rd = 0;
      if (drain_on && fifo_valid) begin
        if (exp_q.size() == 0) chk("R7 stray", {fifo_rsy, fifo_rdata}, 33'h0);
        else chk("R7", {fifo_rsy, fifo_rdata}, exp_q.pop_front());
        fifo_rd = 1;
      end
    end
  end

  task automatic drain();
    drain_on = 1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk); @(negedge clk);
    drain_on = 0;
    m_used = 0;
    chk("R7 drained", {32'b0, fifo_valid}, 33'h0);
  endtask

  // Driver: sends one packet and records the expected outcome
  task automatic send(input logic [1:0] tag, input logic [1:0] spd, input logic sy,
                      input int len, input int n, input logic crc, input string req);
    bit acc  = (tag == cur_tag);
    bit ovf  = acc && (m_used + n > DEPTH);
    bit keep = acc && !ovf && ((len == 0 && n == 0) || (crc && n == len));
    bit quiet = (m_used == 0) && !drain_on;
    int ovf0 = ovf_count;
    @(negedge clk);
    hdr_valid = 1; hdr_tag = tag; hdr_spd = spd; hdr_sy = sy; hdr_len = LEN_W'(len);
    @(negedge clk);
    hdr_valid = 0;
    for (int i = 0; i < n; i++) begin
      data_valid = 1; data_word = 32'hC0DE0000 + serial; serial++;
      if (keep) exp_q.push_back({sy, data_word});
      @(negedge clk);
    end
    data_valid = 0;
    if (quiet && acc && n > 0) chk("R11", {32'b0, fifo_valid}, 33'h0);
    pkt_end = 1; pkt_crc_ok = crc;
    @(negedge clk);
    pkt_end = 0;
    if (acc && !ovf) begin
      m_spd = spd; m_sy = sy; m_err = keep ? 4'b0001 : 4'b1101;
    end
    if (keep) m_used += n;
    chk("R10 overflow pulse", 33'(ovf_count - ovf0), ovf ? 33'd1 : 33'd0);
    check_regs(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd_reg(0, v); chk("R1 control", {1'b0, v}, 33'h0);
    rd_reg(1, v); chk("R1 status", {1'b0, v}, 33'h3);

    wr_reg(32'hFFFF_FFFF);
    rd_reg(0, v); chk("R2 write mask", {1'b0, v}, 33'h0000C000);
    wr_reg(32'h0000_4000); cur_tag = 2'b01;
    rd_reg(0, v); chk("R2 tag 01", {1'b0, v}, 33'h00004000);

    send(2'b01, 2'b10, 1'b1, 4, 4, 1'b1, "R3 s400");
    send(2'b01, 2'b00, 1'b0, 2, 2, 1'b1, "R3 s100");
    send(2'b01, 2'b01, 1'b1, 3, 3, 1'b1, "R3 s200");
    drain();

    send(2'b00, 2'b10, 1'b0, 2, 2, 1'b1, "R6 tag mismatch");
    send(2'b11, 2'b00, 1'b0, 1, 1, 1'b1, "R6 tag mismatch");
    chk("R6 nothing stored", {32'b0, fifo_valid}, 33'h0);

    send(2'b01, 2'b00, 1'b0, 3, 3, 1'b0, "R4 crc");
    send(2'b01, 2'b10, 1'b1, 3, 4, 1'b1, "R4 long");
    send(2'b01, 2'b01, 1'b0, 5, 4, 1'b1, "R4 short");
    send(2'b01, 2'b10, 1'b1, 0, 0, 1'b0, "R5 empty payload");

    send(2'b01, 2'b00, 1'b1, 512, 512, 1'b1, "R9 512 free");
    send(2'b01, 2'b01, 1'b0, 256, 256, 1'b1, "R9 256 free");
    send(2'b01, 2'b10, 1'b1, 156, 156, 1'b1, "R9 100 free");
    send(2'b01, 2'b00, 1'b0, 99, 99, 1'b1, "R9 one free");
    send(2'b01, 2'b10, 1'b1, 3, 3, 1'b1, "R10 overflow");
    send(2'b01, 2'b01, 1'b1, 1, 1, 1'b1, "R9 full");
    rd_reg(1, v); chk("R9 full flags", {1'b0, v}, 33'h78);
    drain();
    rd_reg(1, v); chk("R8 empty again", {1'b0, v}, 33'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule